// File: doc/BRIEF.md
# Binary Morphology Processing-Element Array

A two-dimensional mesh of one-bit processing elements, 8 by 8 by default, all driven by the same instruction in each clock cycle. Each element keeps a working bit, a result bit and four stored binary image planes. In one cycle the whole array can binarize a sampled pixel into the working bit, copy a stored plane into it, shift the working plane one step toward any compass direction, combine the working bit with a stored bit through a logic operation into the result bit, or write the result bit back into a stored plane. A parallel image port writes whole planes from outside. The working plane is visible at the outputs, together with its OR projection onto every row and every column.

Erosion and dilation by a structuring element are built in software as a regular loop with one pass per active element of the structuring element. Each pass loads the source plane, shifts it by that offset, then ANDs (erosion) or ORs (dilation) it with an accumulator plane and stores the result back. The loop has the same shape for every structuring element. The row and column projections give the extent of an object, and an all-zero projection flags an empty image.

Top module: `pe_morph_array`

Bit `r*COLS + c` of every plane-wide bus is the element in row r and column c. Row 0 is the top (north) row and column 0 is the west column.

## Requirements
- R1: After reset, the working bit, the result bit and all four stored planes of every element are 0, so `work_plane`, `row_proj` and `col_proj` read 0.
- R2: The opcode value 1 loads each working bit with 1 when its pixel value is strictly greater than `thr_lo` and strictly less than `thr_hi`, and with 0 otherwise. A value equal to either threshold gives 0.
- R3: The opcode value 2 copies the stored plane selected by `instr_sel` into the working plane.
- R4: Each shift changes working bit (r,c) to a neighbour's value. Opcode 3 takes it from (r+1,c), opcode 4 from (r-1,c), opcode 5 from (r,c-1) and opcode 6 from (r,c+1). A neighbour outside the array supplies 0.
- R5: The opcodes 7, 8, 9 and 10 set the result bit to work AND mem, work OR mem, work XOR mem and work AND NOT mem, where mem is the plane chosen by `instr_sel`. The working bit and the stored planes do not change.
- R6: The opcode value 11 writes the result bit into the plane chosen by `instr_sel`.
- R7: When `instr_valid` is 0, or the opcode is 0 or 12 to 15, no working bit, result bit or stored plane changes.
- R8: When `img_wr_en` is high, the plane chosen by `img_wr_sel` takes `img_wr_data` at that clock edge. If a store to the same plane happens in the same cycle, the port write wins.
- R9: `row_proj[r]` is the OR of the working bits of row r, and `col_proj[c]` is the OR of column c. Both follow the working plane without delay.
- R10: The load, shift, AND-or-OR and store loop over the five offsets of a plus-shaped structuring element leaves the erosion (or dilation) of the source plane in the accumulator plane, with pixels outside the array counted as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | The broadcast instruction is valid this cycle |
| instr_op | input | 4 | Opcode |
| instr_sel | input | 2 | Stored-plane select for load, ALU and store |
| thr_lo | input | PIX_W | Lower binarization threshold (exclusive) |
| thr_hi | input | PIX_W | Upper binarization threshold (exclusive) |
| pix_in | input | ROWS*COLS*PIX_W | Sampled pixel values, element i in bits i*PIX_W and up |
| img_wr_en | input | 1 | Image port write enable |
| img_wr_sel | input | 2 | Plane written by the image port |
| img_wr_data | input | ROWS*COLS | Plane data for the image port |
| work_plane | output | ROWS*COLS | Working-register plane |
| row_proj | output | ROWS | OR of each row of the working plane |
| col_proj | output | COLS | OR of each column of the working plane |

## Verification
Shifts are tried on a plane that has set bits on all four borders. This separates the four directions and shows whether zeros enter at the edge or the image wraps around. Each ALU operation uses two planes that overlap only in part, so that all four input combinations occur and AND, OR, XOR and AND-NOT each give a different result. Binarization uses pixels exactly at each threshold and one step inside it, which tells a strict compare from an inclusive one. The morphology loop runs on an object that touches the array edge and carries a one-pixel spur, so the erosion and dilation results depend both on the border rule and on every one of the five offsets.

// File: rtl/pe_pkg.sv
package pe_pkg;
    localparam int SEL_W  = 2;
    localparam int PLANES = 1 << SEL_W;

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_LDBIN = 4'd1,
        OP_LDMEM = 4'd2,
        OP_SHN   = 4'd3,
        OP_SHS   = 4'd4,
        OP_SHE   = 4'd5,
        OP_SHW   = 4'd6,
        OP_AND   = 4'd7,
        OP_OR    = 4'd8,
        OP_XOR   = 4'd9,
        OP_ANDN  = 4'd10,
        OP_STORE = 4'd11
    } pe_op_e;

    typedef enum logic [2:0] {
        WSRC_HOLD, WSRC_BIN, WSRC_MEM, WSRC_BELOW, WSRC_ABOVE, WSRC_LEFT, WSRC_RIGHT
    } wsrc_e;

    typedef enum logic [1:0] {
        ALU_AND, ALU_OR, ALU_XOR, ALU_ANDN
    } alu_e;

    typedef struct packed {
        wsrc_e            wsrc;
        logic             alu_en;
        alu_e             alu_op;
        logic             store_en;
        logic [SEL_W-1:0] sel;
    } pe_ctl_t;

    typedef struct packed {
        logic              work;
        logic              res;
        logic [PLANES-1:0] mem;
    } cell_st_t;
endpackage

// File: rtl/pe_decode.sv
module pe_decode
    import pe_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  logic [3:0]       op,
    input  logic [SEL_W-1:0] sel,
    output pe_ctl_t          ctl
);
    always_comb begin
        ctl          = '0;
        ctl.wsrc     = WSRC_HOLD;
        ctl.alu_op   = ALU_AND;
        ctl.sel      = sel;
        if (valid) begin
            case (op)
                OP_LDBIN: ctl.wsrc = WSRC_BIN;
                OP_LDMEM: ctl.wsrc = WSRC_MEM;
                OP_SHN:   ctl.wsrc = WSRC_BELOW;
                OP_SHS:   ctl.wsrc = WSRC_ABOVE;
                OP_SHE:   ctl.wsrc = WSRC_LEFT;
                OP_SHW:   ctl.wsrc = WSRC_RIGHT;
                OP_AND:   begin ctl.alu_en = 1'b1; ctl.alu_op = ALU_AND;  end
                OP_OR:    begin ctl.alu_en = 1'b1; ctl.alu_op = ALU_OR;   end
                OP_XOR:   begin ctl.alu_en = 1'b1; ctl.alu_op = ALU_XOR;  end
                OP_ANDN:  begin ctl.alu_en = 1'b1; ctl.alu_op = ALU_ANDN; end
                OP_STORE: ctl.store_en = 1'b1;
                default:  ;
            endcase
        end
    end

    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({ctl.wsrc != WSRC_HOLD, ctl.alu_en, ctl.store_en})); // R7
    AST_INVALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !valid |-> (ctl.wsrc == WSRC_HOLD && !ctl.alu_en && !ctl.store_en)); // R7
endmodule

// File: rtl/pe_cell.sv
module pe_cell
    import pe_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pe_ctl_t          ctl,
    input  logic [PIX_W-1:0] pix,
    input  logic [PIX_W-1:0] thr_lo,
    input  logic [PIX_W-1:0] thr_hi,
    input  logic             nb_below,
    input  logic             nb_above,
    input  logic             nb_left,
    input  logic             nb_right,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic             wr_bit,
    output logic             work_o
);
    cell_st_t st_d, st_q;
    logic     bin_bit;
    logic     mem_bit;

    always_comb begin
        st_d    = st_q;
        bin_bit = (pix > thr_lo) && (pix < thr_hi);
        mem_bit = st_q.mem[ctl.sel];
        case (ctl.wsrc)
            WSRC_BIN:   st_d.work = bin_bit;
            WSRC_MEM:   st_d.work = mem_bit;
            WSRC_BELOW: st_d.work = nb_below;
            WSRC_ABOVE: st_d.work = nb_above;
            WSRC_LEFT:  st_d.work = nb_left;
            WSRC_RIGHT: st_d.work = nb_right;
            default:    ;
        endcase
        if (ctl.alu_en) begin
            case (ctl.alu_op)
                ALU_AND:  st_d.res = st_q.work & mem_bit;
                ALU_OR:   st_d.res = st_q.work | mem_bit;
                ALU_XOR:  st_d.res = st_q.work ^ mem_bit;
                default:  st_d.res = st_q.work & ~mem_bit;
            endcase
        end
        if (ctl.store_en) st_d.mem[ctl.sel] = st_q.res;
        if (wr_en)        st_d.mem[wr_sel]  = wr_bit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign work_o = st_q.work;

    AST_SHIFT_NORTH: assert property (@(posedge clk) disable iff (!rst_n) ctl.wsrc == WSRC_BELOW |=> st_q.work == $past(nb_below)); // R4
    AST_SHIFT_WEST: assert property (@(posedge clk) disable iff (!rst_n) ctl.wsrc == WSRC_RIGHT |=> st_q.work == $past(nb_right)); // R4
    AST_ALU_KEEPS: assert property (@(posedge clk) disable iff (!rst_n) (ctl.alu_en && !wr_en) |=> ($stable(st_q.work) && $stable(st_q.mem))); // R5
    AST_STORE_WB: assert property (@(posedge clk) disable iff (!rst_n) (ctl.store_en && !(wr_en && wr_sel == ctl.sel)) |=> st_q.mem[$past(ctl.sel)] == $past(st_q.res)); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (ctl.wsrc == WSRC_HOLD && !ctl.alu_en && !ctl.store_en && !wr_en) |=> $stable(st_q)); // R7
    AST_PORT_WINS: assert property (@(posedge clk) disable iff (!rst_n) wr_en |=> st_q.mem[$past(wr_sel)] == $past(wr_bit)); // R8
endmodule

// File: rtl/pe_projection.sv
module pe_projection #(
    parameter int ROWS = 8,
    parameter int COLS = 8,
    localparam int N   = ROWS * COLS
) (
    input  logic [N-1:0]    plane,
    output logic [ROWS-1:0] row_or,
    output logic [COLS-1:0] col_or
);
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign row_or[r] = |plane[r*COLS +: COLS];
    end

    always_comb begin
        col_or = '0;
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                col_or[c] = col_or[c] | plane[r*COLS + c];
            end
        end
    end
endmodule

// File: rtl/pe_morph_array.sv
module pe_morph_array
    import pe_pkg::*;
#(
    parameter int ROWS  = 8,
    parameter int COLS  = 8,
    parameter int PIX_W = 8,
    localparam int N    = ROWS * COLS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               instr_valid,
    input  logic [3:0]         instr_op,
    input  logic [SEL_W-1:0]   instr_sel,
    input  logic [PIX_W-1:0]   thr_lo,
    input  logic [PIX_W-1:0]   thr_hi,
    input  logic [N*PIX_W-1:0] pix_in,
    input  logic               img_wr_en,
    input  logic [SEL_W-1:0]   img_wr_sel,
    input  logic [N-1:0]       img_wr_data,
    output logic [N-1:0]       work_plane,
    output logic [ROWS-1:0]    row_proj,
    output logic [COLS-1:0]    col_proj
);
    pe_ctl_t      ctl;
    logic [N-1:0] work_w;

    pe_decode i_decode (
        .clk   (clk),
        .rst_n (rst_n),
        .valid (instr_valid),
        .op    (instr_op),
        .sel   (instr_sel),
        .ctl   (ctl)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_r
        for (genvar c = 0; c < COLS; c++) begin : g_c
            localparam int IDX = r*COLS + c;
            logic below_b, above_b, left_b, right_b;

            if (r == ROWS-1) begin : g_bot
                assign below_b = 1'b0;
            end else begin : g_nbot
                assign below_b = work_w[IDX + COLS];
            end
            if (r == 0) begin : g_top
                assign above_b = 1'b0;
            end else begin : g_ntop
                assign above_b = work_w[IDX - COLS];
            end
            if (c == 0) begin : g_lft
                assign left_b = 1'b0;
            end else begin : g_nlft
                assign left_b = work_w[IDX - 1];
            end
            if (c == COLS-1) begin : g_rgt
                assign right_b = 1'b0;
            end else begin : g_nrgt
                assign right_b = work_w[IDX + 1];
            end

            pe_cell #(.PIX_W(PIX_W)) i_cell (
                .clk      (clk),
                .rst_n    (rst_n),
                .ctl      (ctl),
                .pix      (pix_in[IDX*PIX_W +: PIX_W]),
                .thr_lo   (thr_lo),
                .thr_hi   (thr_hi),
                .nb_below (below_b),
                .nb_above (above_b),
                .nb_left  (left_b),
                .nb_right (right_b),
                .wr_en    (img_wr_en),
                .wr_sel   (img_wr_sel),
                .wr_bit   (img_wr_data[IDX]),
                .work_o   (work_w[IDX])
            );
        end
    end

    pe_projection #(.ROWS(ROWS), .COLS(COLS)) i_proj (
        .plane  (work_w),
        .row_or (row_proj),
        .col_or (col_proj)
    );

    assign work_plane = work_w;

    AST_PROJ_AGREE: assert property (@(posedge clk) disable iff (!rst_n) (|row_proj) == (|col_proj)); // R9
    AST_PROJ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) (work_plane == '0) == (row_proj == '0)); // R9
endmodule

// File: tb/test_pe_morph_array.sv
module test_pe_morph_array;
    localparam int R  = 8;
    localparam int C  = 8;
    localparam int N  = R * C;
    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          instr_valid = 1'b0;
    logic [3:0]    instr_op = '0;
    logic [1:0]    instr_sel = '0;
    logic [PW-1:0] thr_lo = 8'd50;
    logic [PW-1:0] thr_hi = 8'd100;
    logic [N*PW-1:0] pix_in;
    logic          img_wr_en = 1'b0;
    logic [1:0]    img_wr_sel = '0;
    logic [N-1:0]  img_wr_data = '0;
    logic [N-1:0]  work_plane;
    logic [R-1:0]  row_proj;
    logic [C-1:0]  col_proj;

    always #5 clk = ~clk;

    pe_morph_array i_pe_morph_array (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_op(instr_op),
        .instr_sel(instr_sel), .thr_lo(thr_lo), .thr_hi(thr_hi), .pix_in(pix_in),
        .img_wr_en(img_wr_en), .img_wr_sel(img_wr_sel), .img_wr_data(img_wr_data),
        .work_plane(work_plane), .row_proj(row_proj), .col_proj(col_proj)
    );

    int n_checks = 0;
    int n_fail = 0;
    logic [N-1:0] exp_q[$];
    string        tag_q[$];
    event         chk_ev;

    logic [N-1:0]      m_work = '0;
    logic [N-1:0]      m_res  = '0;
    logic [3:0][N-1:0] m_mem  = '0;
    int                pixv[N];

    function automatic logic get_bit(logic [N-1:0] x, int r, int c);
        if (r < 0 || r >= R || c < 0 || c >= C) return 1'b0;
        return x[r*C + c];
    endfunction

    function automatic logic [N-1:0] shifted(logic [N-1:0] x, int dr, int dc);
        logic [N-1:0] y;
        for (int r = 0; r < R; r++)
            for (int c = 0; c < C; c++)
                y[r*C + c] = get_bit(x, r + dr, c + dc);
        return y;
    endfunction

    function automatic logic [N-1:0] morph(logic [N-1:0] x, bit erode);
        logic [N-1:0] y;
        for (int r = 0; r < R; r++)
            for (int c = 0; c < C; c++) begin
                logic a, b, u, d, l;
                a = get_bit(x, r, c);   u = get_bit(x, r-1, c); d = get_bit(x, r+1, c);
                l = get_bit(x, r, c-1); b = get_bit(x, r, c+1);
                y[r*C + c] = erode ? (a & u & d & l & b) : (a | u | d | l | b);
            end
        return y;
    endfunction

    function automatic logic [R-1:0] rows_of(logic [N-1:0] x);
        logic [R-1:0] y = '0;
        for (int r = 0; r < R; r++)
            for (int c = 0; c < C; c++) y[r] = y[r] | x[r*C + c];
        return y;
    endfunction

    function automatic logic [C-1:0] cols_of(logic [N-1:0] x);
        logic [C-1:0] y = '0;
        for (int r = 0; r < R; r++)
            for (int c = 0; c < C; c++) y[c] = y[c] | x[r*C + c];
        return y;
    endfunction

    task automatic check(input string what, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", what, act, exp);
        end
    endtask

    // Monitor: pops expected working planes and compares plane and projections
    initial begin
        forever begin
            @(chk_ev);
            #1;
            while (exp_q.size() > 0) begin
                logic [N-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({t, " plane"}, work_plane, e);
                check({t, " R9 rows"}, N'(row_proj), N'(rows_of(e)));
                check({t, " R9 cols"}, N'(col_proj), N'(cols_of(e)));
            end
        end
    end

    // Driver: one instruction (and optional port write), model update, expectation push
    task automatic issue(input logic v, input logic [3:0] op, input logic [1:0] sel,
                         input logic w, input logic [1:0] ws, input logic [N-1:0] wd,
                         input string tag);
        logic [N-1:0]      nw;
        logic [N-1:0]      nr;
        logic [3:0][N-1:0] nm;
        @(negedge clk);
        instr_valid = v; instr_op = op; instr_sel = sel;
        img_wr_en = w; img_wr_sel = ws; img_wr_data = wd;
        @(posedge clk);
        nw = m_work; nr = m_res; nm = m_mem;
        if (v) begin
            case (op)
                4'd1: for (int i = 0; i < N; i++) nw[i] = (pixv[i] > int'(thr_lo)) && (pixv[i] < int'(thr_hi));
                4'd2: nw = m_mem[sel];
                4'd3: nw = shifted(m_work, 1, 0);
                4'd4: nw = shifted(m_work, -1, 0);
                4'd5: nw = shifted(m_work, 0, -1);
                4'd6: nw = shifted(m_work, 0, 1);
                4'd7: nr = m_work & m_mem[sel];
                4'd8: nr = m_work | m_mem[sel];
                4'd9: nr = m_work ^ m_mem[sel];
                4'd10: nr = m_work & ~m_mem[sel];
                4'd11: nm[sel] = m_res;
                default: ;
            endcase
        end
        if (w) nm[ws] = wd;
        m_work = nw; m_res = nr; m_mem = nm;
        #1;
        exp_q.push_back(m_work);
        tag_q.push_back(tag);
        -> chk_ev;
        @(negedge clk);
        instr_valid = 1'b0; img_wr_en = 1'b0;
    endtask

    task automatic op1(input logic [3:0] op, input logic [1:0] sel, input string tag);
        issue(1'b1, op, sel, 1'b0, 2'd0, '0, tag);
    endtask

    task automatic wr(input logic [1:0] ws, input logic [N-1:0] wd, input string tag);
        issue(1'b0, 4'd0, 2'd0, 1'b1, ws, wd, tag);
    endtask

    task automatic run_morph(input bit erode, input logic [1:0] acc, input string tag);
        int dr[5] = '{0, 1, -1, 0, 0};
        int dc[5] = '{0, 0, 0, 1, -1};
        for (int k = 0; k < 5; k++) begin
            op1(4'd2, 2'd0, tag);
            if (dr[k] == 1)  op1(4'd3, 2'd0, tag);
            if (dr[k] == -1) op1(4'd4, 2'd0, tag);
            if (dc[k] == 1)  op1(4'd6, 2'd0, tag);
            if (dc[k] == -1) op1(4'd5, 2'd0, tag);
            op1(erode ? 4'd7 : 4'd8, acc, tag);
            op1(4'd11, acc, tag);
        end
        op1(4'd2, acc, tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [N-1:0] pa, pb, img;
        for (int i = 0; i < N; i++) pixv[i] = (i * 37) % 160;
        pixv[0] = 50; pixv[1] = 100; pixv[2] = 51; pixv[3] = 99; pixv[4] = 49; pixv[5] = 101;
        for (int i = 0; i < N; i++) pix_in[i*PW +: PW] = PW'(pixv[i]);

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 reset plane", work_plane, '0);
        check("R1 reset rows", N'(row_proj), '0);
        check("R1 reset cols", N'(col_proj), '0);
        for (int p = 0; p < 4; p++) op1(4'd2, 2'(p), "R1 reset memory plane");

        op1(4'd1, 2'd0, "R2 binarize strict thresholds");

        pa = 64'h81C3_0024_1800_A5FF;
        pb = 64'h0FF0_33CC_5A5A_F00F;
        wr(2'd0, pa, "R8 port write leaves work");
        op1(4'd2, 2'd0, "R3 load plane 0");
        op1(4'd3, 2'd0, "R4 shift north");
        op1(4'd2, 2'd0, "R3 reload");
        op1(4'd4, 2'd0, "R4 shift south");
        op1(4'd2, 2'd0, "R3 reload");
        op1(4'd5, 2'd0, "R4 shift east");
        op1(4'd2, 2'd0, "R3 reload");
        op1(4'd6, 2'd0, "R4 shift west");
        op1(4'd6, 2'd0, "R4 shift west twice");

        wr(2'd1, pb, "R8 port write plane 1");
        for (int k = 0; k < 4; k++) begin
            op1(4'd2, 2'd0, "R3 reload");
            op1(4'(7 + k), 2'd1, "R5 ALU keeps work");
            op1(4'd11, 2'd2, "R6 store result");
            op1(4'd2, 2'd2, "R5 R6 ALU result readback");
        end

        op1(4'd2, 2'd0, "R3 reload");
        issue(1'b0, 4'd3, 2'd0, 1'b0, 2'd0, '0, "R7 invalid shift ignored");
        op1(4'd13, 2'd0, "R7 unused opcode ignored");
        op1(4'd0, 2'd0, "R7 nop ignored");
        issue(1'b0, 4'd11, 2'd1, 1'b0, 2'd0, '0, "R7 invalid store");
        op1(4'd2, 2'd1, "R7 plane 1 untouched");

        op1(4'd7, 2'd0, "R5 AND for conflict");
        issue(1'b1, 4'd11, 2'd3, 1'b1, 2'd3, 64'h0000_0010_0000_0000, "R8 port beats store");
        op1(4'd2, 2'd3, "R8 port data kept");

        img = 64'h0000_3C7E_7E3C_1800;
        img[0] = 1'b1; img[1] = 1'b1; img[8] = 1'b1;
        img[6*C + 6] = 1'b1;
        wr(2'd0, img, "R10 source");
        wr(2'd1, '1, "R10 erosion accumulator");
        wr(2'd2, '0, "R10 dilation accumulator");
        run_morph(1'b1, 2'd1, "R10 erosion");
        check("R10 erosion bench", work_plane, morph(img, 1'b1));
        run_morph(1'b0, 2'd2, "R10 dilation");
        check("R10 dilation bench", work_plane, morph(img, 1'b0));

        @(negedge clk);
        #1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule